// File: doc/BRIEF.md
# Magic Divisor Constant Generator

This sequential block turns an unsigned divisor `d` into the constants that an index unit needs to divide by `d` with one multiply and one right shift instead of a true divider. It returns a shift value equal to the position of the most significant set bit of `d`, a multiplier taken from the exact quotient of a power of two by `d`, and a flag that tells the consumer to apply the round-down correction. The correction adds the multiplier once more before the shift, so the consumer computes `(n + round_down) * mult`, shifts right by `DW`, and then shifts right again by `shift`.

The caller presents `divisor` with a one-cycle `start` while `busy` is low. A divisor with several set bits runs through a restoring divider that retires one quotient bit per clock over a dividend of twice the divisor width. A divisor that is a power of two is answered at once with `pow2` set, so the caller can fall back to a plain shift. A divisor of 0 or 1 is refused at once with `err`. The results stay on the outputs until the next accepted request.

Top module: `magic_div_gen`

## Requirements
- R1: For every divisor of 2 or more, `shift` equals floor(log2(d)), the index of the highest set bit of `d`.
- R2: For a divisor that is not a power of two, let P = 2^(shift+DW), q = floor(P/d), e = P mod d, m = q + 1 (e is never 0). When e <= 2^shift, `round_down` is 1 and `mult` is m-1.
- R3: In the same case, when e > 2^shift, `round_down` is 0 and `mult` is m.
- R4: For a divisor that is not a power of two, bit DW-1 of `mult` is always 1, so the multiplier lies in [2^(DW-1), 2^DW).
- R5: A divisor with exactly one set bit gives `done` with `pow2` = 1 and `err` = 0 in the cycle after the accepting edge. `mult` = 0 and `round_down` = 0 in that case.
- R6: A divisor of 0 or 1 gives `done` with `err` = 1 and `pow2` = 0 in the cycle after the accepting edge. `shift`, `mult` and `round_down` are all 0 in that case, and no division is run.
- R7: For a divisor that is not a power of two, `done` is high in the cycle after the (2*DW+1)-th rising edge that follows the accepting edge. With DW = 32, that is 66 sampling points after the request.
- R8: `done` is a single-cycle pulse. `busy` is high from the accepting edge until `done` rises, and `busy` and `done` are never high together.
- R9: A `start` while `busy` is high is ignored. It changes neither the result nor the timing of the running request. The outputs hold their value while `busy` is high and after `done`, until the next accepted request.
- R10: For every DW-bit dividend n, the constants give floor(n/d) = ((n + round_down) * mult) >> (DW + shift).
- R11: After reset, `busy`, `done`, `err`, `pow2`, `shift`, `mult` and `round_down` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, accepted only while `busy` is low |
| divisor | input | DW | Divisor d, sampled with `start` |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse marking valid results |
| err | output | 1 | Divisor was 0 or 1 |
| pow2 | output | 1 | Divisor is a power of two; use plain shift |
| shift | output | $clog2(DW) | floor(log2(d)) |
| mult | output | DW | Magic multiplier |
| round_down | output | 1 | Apply the round-down correction (add n+1 instead of n) |

## Verification
The results fall due at two points. The short answers (error and power of two) are due at the first sampling point after the accepting edge. The long answer is due 2*DW+2 sampling points after the request: one edge to load, 2*DW edges for the divide steps, and one edge to form the result. The bench drives `start` on a falling edge and counts falling edges until `done` appears. It compares that count with the exact value for each path and then reads the results at the same falling edge. The bound checker keeps its own cycle counter from the accepting edge, so it checks the same latencies on every request, including when a second `start` arrives during a run.

// File: rtl/magic_div_pkg.sv
package magic_div_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FIN  = 2'd2
    } phase_e;
endpackage

// File: rtl/magic_msb.sv
// Locates the highest set bit of a word and reports whether it is the only one.
module magic_msb #(
    parameter int W  = 32,
    localparam int PW = $clog2(W)
) (
    input  logic [W-1:0]  val,
    output logic [PW-1:0] pos,
    output logic          single
);
    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (val[i]) pos = PW'(i);
        end
    end

    assign single = (val != '0) && ((val & (val - W'(1))) == '0);
endmodule

// File: rtl/magic_div_step.sv
// One restoring division step: shift one dividend bit into the remainder, subtract if it fits.
module magic_div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_in,
    input  logic         bit_in,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] rem_out,
    output logic         q_bit
);
    logic [W:0] trial;
    logic [W:0] diff;

    always_comb begin
        trial = {rem_in, bit_in};
        diff  = trial - {1'b0, dvs};
        q_bit = (trial >= {1'b0, dvs});
        rem_out = q_bit ? diff[W-1:0] : trial[W-1:0];
    end
endmodule

// File: rtl/magic_finish.sv
// Forms the multiplier and round-down choice from the final quotient and remainder.
module magic_finish #(
    parameter int W  = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [W:0]    quot,
    input  logic [W-1:0]  rem,
    input  logic [SW-1:0] sh,
    output logic [W-1:0]  mult,
    output logic          rdown
);
    logic [W:0] limit;

    always_comb begin
        limit = (W+1)'(1) << sh;
        // the remainder is never zero here, so the ceiling is quotient + 1
        rdown = ({1'b0, rem} <= limit);
        mult  = rdown ? quot[W-1:0] : (quot[W-1:0] + W'(1));
    end
endmodule

// File: rtl/magic_div_gen.sv
module magic_div_gen
    import magic_div_pkg::*;
#(
    parameter int DW = 32,
    localparam int SW = $clog2(DW),
    localparam int CW = $clog2(2*DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] divisor,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          pow2,
    output logic [SW-1:0] shift,
    output logic [DW-1:0] mult,
    output logic          round_down
);
    localparam logic [CW-1:0] LAST_IDX = CW'(2*DW - 1);

    typedef struct packed {
        phase_e        ph;
        logic [DW-1:0] dvs;
        logic [SW-1:0] sh;
        logic [CW-1:0] idx;
        logic [DW-1:0] rem;
        logic [DW:0]   quot;
        logic          done;
        logic          err;
        logic          pow2;
        logic [SW-1:0] sh_out;
        logic [DW-1:0] mult;
        logic          rdown;
    } state_t;

    state_t st_d, st_q;

    logic [SW-1:0] msb_pos;
    logic          msb_single;
    logic          dvd_bit;
    logic [DW-1:0] step_rem;
    logic          step_q;
    logic [DW-1:0] fin_mult;
    logic          fin_rdown;

    magic_msb #(.W(DW)) u_msb (
        .val    (divisor),
        .pos    (msb_pos),
        .single (msb_single)
    );

    // the dividend 2^(sh+DW) has a single one bit
    assign dvd_bit = (st_q.idx == (CW'(st_q.sh) + CW'(DW)));

    magic_div_step #(.W(DW)) u_step (
        .rem_in  (st_q.rem),
        .bit_in  (dvd_bit),
        .dvs     (st_q.dvs),
        .rem_out (step_rem),
        .q_bit   (step_q)
    );

    magic_finish #(.W(DW)) u_fin (
        .quot  (st_q.quot),
        .rem   (st_q.rem),
        .sh    (st_q.sh),
        .mult  (fin_mult),
        .rdown (fin_rdown)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    if (divisor < DW'(2)) begin
                        st_d.done   = 1'b1;
                        st_d.err    = 1'b1;
                        st_d.pow2   = 1'b0;
                        st_d.sh_out = '0;
                        st_d.mult   = '0;
                        st_d.rdown  = 1'b0;
                    end else if (msb_single) begin
                        st_d.done   = 1'b1;
                        st_d.err    = 1'b0;
                        st_d.pow2   = 1'b1;
                        st_d.sh_out = msb_pos;
                        st_d.mult   = '0;
                        st_d.rdown  = 1'b0;
                    end else begin
                        st_d.ph   = PH_RUN;
                        st_d.dvs  = divisor;
                        st_d.sh   = msb_pos;
                        st_d.idx  = LAST_IDX;
                        st_d.rem  = '0;
                        st_d.quot = '0;
                    end
                end
            end
            PH_RUN: begin
                st_d.rem  = step_rem;
                st_d.quot = {st_q.quot[DW-1:0], step_q};
                if (st_q.idx == '0) begin
                    st_d.ph = PH_FIN;
                end else begin
                    st_d.idx = st_q.idx - CW'(1);
                end
            end
            PH_FIN: begin
                st_d.ph     = PH_IDLE;
                st_d.done   = 1'b1;
                st_d.err    = 1'b0;
                st_d.pow2   = 1'b0;
                st_d.sh_out = st_q.sh;
                st_d.mult   = fin_mult;
                st_d.rdown  = fin_rdown;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy       = (st_q.ph != PH_IDLE);
    assign done       = st_q.done;
    assign err        = st_q.err;
    assign pow2       = st_q.pow2;
    assign shift      = st_q.sh_out;
    assign mult       = st_q.mult;
    assign round_down = st_q.rdown;
endmodule

// File: rtl/magic_div_gen_chk.sv
module magic_div_gen_chk #(
    parameter int DW = 32,
    localparam int SW = $clog2(DW),
    localparam int LAT = 2*DW + 2,
    localparam int KW = $clog2(LAT + 2) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [DW-1:0] divisor,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic          pow2,
    input logic [SW-1:0] shift,
    input logic [DW-1:0] mult,
    input logic          round_down
);
    logic [DW-1:0]   d_cap;
    logic [KW-1:0]   cnt;
    logic [2*DW-1:0] prod;
    logic [2*DW-1:0] pw;
    logic [2*DW-1:0] lim;
    logic [2*DW-1:0] d_ext;
    logic            accept;

    assign accept = start && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_cap <= '0;
            cnt   <= '0;
        end else begin
            if (accept) begin
                d_cap <= divisor;
                cnt   <= KW'(1);
            end else if (done) begin
                cnt <= '0;
            end else if (cnt != '0) begin
                cnt <= cnt + KW'(1);
            end
        end
    end

    always_comb begin
        d_ext = (2*DW)'(d_cap);
        prod  = (2*DW)'(mult) * d_ext;
        pw    = (2*DW)'(1) << ((2*DW)'(shift) + (2*DW)'(DW));
        lim   = (2*DW)'(1) << shift;
    end

    AST_SHIFT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        done && !err |-> (d_cap >> shift) == DW'(1)); // R1

    AST_ROUND_DOWN_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        done && !err && !pow2 && round_down |-> prod < pw && (pw - prod) <= lim && (prod + d_ext) > pw); // R2

    AST_PLAIN_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        done && !err && !pow2 && !round_down |-> prod > pw && (prod - d_ext) < pw && (pw - (prod - d_ext)) > lim); // R3

    AST_MULT_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        done && !err && !pow2 |-> mult[DW-1]); // R4

    AST_POW2_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        done && pow2 |-> cnt == KW'(1) && mult == '0 && !round_down && !err); // R5

    AST_ERR_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && divisor < DW'(2) |=> done && err && !pow2 && mult == '0 && shift == '0); // R6

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done && !err && !pow2 |-> cnt == KW'(LAT)); // R7

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done); // R8

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(mult) && $stable(shift) && $stable(round_down)); // R9
endmodule

bind magic_div_gen magic_div_gen_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .divisor    (divisor),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .pow2       (pow2),
    .shift      (shift),
    .mult       (mult),
    .round_down (round_down)
);

// File: tb/magic_div_gen_bench.sv
module magic_div_gen_bench;
    localparam int DW  = 32;
    localparam int SW  = $clog2(DW);
    localparam int LONG_LAT = 2*DW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] divisor = '0;
    logic          busy, done, err, pow2, round_down;
    logic [SW-1:0] shift;
    logic [DW-1:0] mult;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    magic_div_gen #(.DW(DW)) u_magic_div_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .divisor(divisor),
        .busy(busy), .done(done), .err(err), .pow2(pow2),
        .shift(shift), .mult(mult), .round_down(round_down)
    );

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int floor_log2(input logic [DW-1:0] d);
        int r = 0;
        for (int i = 0; i < DW; i++) if (d[i]) r = i;
        return r;
    endfunction

    // constants from the requirement formula, with plain 64-bit arithmetic
    task automatic expect_consts(input logic [DW-1:0] d, output int s, output logic [DW-1:0] em, output logic erd);
        logic [63:0] p, q, e, m;
        s  = floor_log2(d);
        p  = 64'd1 << (s + DW);
        q  = p / 64'(d);
        e  = p % 64'(d);
        m  = (e != 0) ? q + 64'd1 : q;
        erd = (e <= (64'd1 << s));
        em = erd ? DW'(m - 64'd1) : DW'(m);
    endtask

    function automatic logic [DW-1:0] model_div(input logic [DW-1:0] n, input logic [DW-1:0] m,
                                                input logic rd, input int s);
        logic [65:0] t;
        t = (66'(n) + 66'(rd)) * 66'(m);
        return DW'(t >> (DW + s));
    endfunction

    // issue one request and wait for done; returns sampling points taken
    task automatic request(input logic [DW-1:0] d, output int lat);
        @(negedge clk);
        divisor = d;
        start = 1'b1;
        lat = 0;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R11", "busy", 64'(busy), 0);
        check("R11", "done", 64'(done), 0);
        check("R11", "outputs", {err, pow2, round_down, 5'(shift), 24'd0, mult}, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_error(input logic [DW-1:0] d);
        int lat;
        request(d, lat);
        check("R6", "err latency", 64'(lat), 1);
        check("R6", "err flag", 64'(err), 1);
        check("R6", "pow2 flag", 64'(pow2), 0);
        check("R6", "zeroed outputs", {27'd0, 5'(shift), mult} | 64'(round_down), 0);
        @(negedge clk);
        check("R8", "done pulse ends", 64'(done), 0);
    endtask

    task automatic t_pow2(input logic [DW-1:0] d);
        int lat;
        request(d, lat);
        check("R5", "pow2 latency", 64'(lat), 1);
        check("R5", "pow2 flag", 64'(pow2), 1);
        check("R5", "no error", 64'(err), 0);
        check("R1", "pow2 shift", 64'(shift), 64'(floor_log2(d)));
        check("R5", "mult and round_down", 64'(mult) | 64'(round_down), 0);
    endtask

    task automatic t_divisor(input logic [DW-1:0] d, input int ndiv);
        int lat, s;
        logic [DW-1:0] em, n;
        logic erd;
        expect_consts(d, s, em, erd);
        request(d, lat);
        check("R7", "long latency", 64'(lat), 64'(LONG_LAT));
        check("R1", "shift", 64'(shift), 64'(s));
        if (erd) check("R2", "round-down mult", {63'd0, round_down} << 32 | 64'(mult), {31'd0, 1'b1, em});
        else     check("R3", "plain mult", {63'd0, round_down} << 32 | 64'(mult), {32'd0, em});
        check("R4", "top bit", 64'(mult[DW-1]), 1);
        check("R10", "n=max", 64'(model_div('1, mult, round_down, int'(shift))), 64'({DW{1'b1}} / d));
        check("R10", "n=d-1", 64'(model_div(d - 1, mult, round_down, int'(shift))), 0);
        check("R10", "n=d", 64'(model_div(d, mult, round_down, int'(shift))), 1);
        for (int k = 0; k < ndiv; k++) begin
            n = $urandom;
            check("R10", "random dividend", 64'(model_div(n, mult, round_down, int'(shift))), 64'(n / d));
        end
    endtask

    task automatic t_busy_ignore;
        int lat, s;
        logic [DW-1:0] em;
        logic erd;
        expect_consts(32'd7, s, em, erd);
        @(negedge clk);
        divisor = 32'd7;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        repeat (9) begin @(negedge clk); lat++; end
        divisor = 32'd11;
        start = 1'b1;
        @(negedge clk);
        lat++;
        start = 1'b0;
        check("R9", "busy during run", 64'(busy), 1);
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        check("R9", "timing kept", 64'(lat), 64'(LONG_LAT));
        check("R9", "result of first divisor", 64'(mult), 64'(em));
        check("R8", "busy low at done", 64'(busy), 0);
        lat = 0;
        repeat (80) begin @(negedge clk); if (done) lat++; end
        check("R9", "no second result", 64'(lat), 0);
        check("R9", "outputs held", 64'(mult), 64'(em));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        t_reset();
        t_error(32'd0);
        t_error(32'd1);
        t_pow2(32'd2);
        t_pow2(32'd64);
        t_pow2(32'h8000_0000);
        t_divisor(32'd3, 8);     // R2
        t_divisor(32'd5, 8);
        t_divisor(32'd7, 8);
        t_divisor(32'd11, 8);    // R3
        t_divisor(32'd6, 8);
        t_divisor(32'hFFFF_FFFF, 8);
        t_divisor(32'h8000_0001, 8);
        t_busy_ignore();
        for (int j = 0; j < 40; j++) begin
            d = $urandom >> ($urandom % 30);
            if (d < 2 || (d & (d - 1)) == 0) d = d | 32'd3;
            t_divisor(d, 20);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule